// File: doc/BRIEF.md
# Time-Sliced Gray-Code Hit Counter Array

This block counts discriminator hits for a small square pixel array during a beam train and keeps the counts for later serial readout. Each pixel has an 8-bit counter that steps through Gray code, so two successive values differ in exactly one bit. The counter stops at the top value instead of wrapping. The counting window of one train is split into a fixed number of consecutive time slices. A slice-end strobe copies every pixel's running count into that slice's register and starts the counter again from zero.

After the last slice the window closes. Counting resumes only when the next train-start strobe arrives, which also clears every slice register. In the long gap between trains the readout side takes over. A pixel is chosen with two token shift registers, one for columns and one for rows. A read index then steps through the slice registers of the chosen pixel, one per read strobe. Each value is presented either as the stored Gray code or converted to plain binary. Counting and slice storage are suspended for as long as readout mode is held.

Top module: `gsc_array_top`

## Requirements
- R1: While the window is open and readout mode is low, each clock cycle with a pixel's hit input high advances that pixel's count by exactly one. Hits on consecutive cycles are all counted, and each stored value is the Gray code of the count (gray = bin ^ (bin >> 1)).
- R2: A pixel count that has reached binary 255 (Gray 8'h80) stays at that value on further hits within the same slice.
- R3: On a slice-end strobe, the running count of every pixel goes into the register of the current slice, and the counter restarts in the same cycle. A hit in that cycle is credited to the next slice as a count of one.
- R4: A train has 16 slices, filled in order 0 to 15. After the 16th slice-end, hits and further slice-end strobes have no effect until the next train-start.
- R5: A train-start strobe clears all slice registers of all pixels, opens the window at slice 0, and counts a hit that arrives in the same cycle.
- R6: While readout mode is high, hits are not counted and slice-end strobes are ignored. The running count is kept and counting resumes when readout mode goes low.
- R7: The read index is set to 0 in the first cycle of readout mode and advances by one on each read strobe. After 15 it goes back to 0.
- R8: With the format input at 0, the read data is the stored Gray code. With the format input at 1, the read data is that value converted to binary.
- R9: The column and row token registers each shift in their data bit at stage 0 on a step strobe, and they hold otherwise. Pixel index row*3+column is selected when both its column stage and its row stage hold a one. A token entered on the first step reaches column 2 on the third step.
- R10: The read data is 0 when readout mode is low or when no pixel is selected.
- R11: After reset all slice registers read as 0, no pixel is selected, the read index is 0 and the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 9 | Synchronized hit, one bit per pixel (row*3+column) |
| train_start_i | input | 1 | Train-start strobe |
| slice_end_i | input | 1 | Slice boundary strobe |
| readout_i | input | 1 | Readout mode level |
| rd_strobe_i | input | 1 | Advance read index |
| fmt_bin_i | input | 1 | 1 = binary read data, 0 = Gray |
| xstep_i | input | 1 | Column token shift strobe |
| xbit_i | input | 1 | Column token data bit |
| ystep_i | input | 1 | Row token shift strobe |
| ybit_i | input | 1 | Row token data bit |
| pix_sel_o | output | 9 | Selected pixels |
| rd_idx_o | output | 4 | Current read slice index |
| data_o | output | 8 | Read data of the selected pixel |

## Verification
Saturation is the hardest case to reach from the ports, because one pixel must see more than 255 hit cycles inside a single slice. The stimulus holds pixel 0's hit high for 300 cycles in slice 5 while the other pixels follow a per-slice pattern. A hit that coincides with a slice boundary or a train start is driven on purpose. The runs then check that the first count of the new slice is one. Readout mode is raised in the middle of an open window while hits and a boundary are driven, and the slice values read back afterwards show that nothing moved.

// File: rtl/gsc_pkg.sv
// Shared count type and Gray/binary conversions for the hit counter array.
// Assumes one common count width for all pixels.
package gsc_pkg;
    localparam int CNT_W = 8;
    typedef logic [CNT_W-1:0] count_t;
    localparam count_t GRAY_MAX = count_t'(1) << (CNT_W - 1);

    // Binary to reflected Gray code.
    function automatic count_t bin2gray(input count_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code to binary, MSB first.
    function automatic count_t gray2bin(input count_t g);
        count_t b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/gsc_pixel.sv
// One pixel: saturating Gray-code hit counter plus one register per slice.
// Assumes the controls from the sequencer are mutually prioritised:
// clear over store over count.
module gsc_pixel
    import gsc_pkg::*;
#(
    parameter int NUM_SLICES = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             count_en_i,
    input  logic             clear_i,
    input  logic             store_i,
    input  logic [IDX_W-1:0] store_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output count_t           rd_gray_o
);
    count_t cnt_q;
    count_t slot_q [NUM_SLICES];
    count_t cnt_bin;
    count_t cnt_inc;
    count_t cnt_first;

    // Next Gray value with saturation, and first value of a new slice.
    always_comb begin
        cnt_bin   = gray2bin(cnt_q);
        cnt_inc   = (cnt_bin == '1) ? cnt_q : bin2gray(cnt_bin + count_t'(1));
        cnt_first = (hit_i && count_en_i) ? bin2gray(count_t'(1)) : '0;
    end

    // Counter and slice register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int s = 0; s < NUM_SLICES; s++) slot_q[s] <= '0;
        end else if (clear_i) begin
            cnt_q <= cnt_first;
            for (int s = 0; s < NUM_SLICES; s++) slot_q[s] <= '0;
        end else if (store_i) begin
            slot_q[store_idx_i] <= cnt_q;
            cnt_q               <= cnt_first;
        end else if (count_en_i && hit_i) begin
            cnt_q <= cnt_inc;
        end
    end

    assign rd_gray_o = slot_q[rd_idx_i];

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !store_i) |=> ($countones(cnt_q ^ $past(cnt_q)) <= 1)); // R1
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == GRAY_MAX && hit_i && count_en_i && !clear_i && !store_i) |=> (cnt_q == GRAY_MAX)); // R2
    AST_SLICE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !clear_i) |=> (cnt_q == ($past(hit_i && count_en_i) ? count_t'(1) : count_t'(0)))); // R3
    AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !clear_i && !store_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/gsc_sequencer.sv
// Train window and readout index control shared by all pixels.
// Assumes strobes are single-cycle; readout_i is a level.
module gsc_sequencer #(
    parameter int NUM_SLICES = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_start_i,
    input  logic             slice_end_i,
    input  logic             readout_i,
    input  logic             rd_strobe_i,
    output logic             count_en_o,
    output logic             clear_o,
    output logic             store_o,
    output logic [IDX_W-1:0] store_idx_o,
    output logic [IDX_W-1:0] rd_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLICES - 1);

    logic             open_q;
    logic [IDX_W-1:0] ptr_q;
    logic             rd_mode_q;
    logic [IDX_W-1:0] rd_idx_q;

    // Decode per-cycle pixel controls.
    always_comb begin
        clear_o     = train_start_i;
        count_en_o  = (open_q || train_start_i) && !readout_i;
        store_o     = slice_end_i && open_q && !readout_i && !train_start_i;
        store_idx_o = ptr_q;
    end

    // Window state and slice pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            ptr_q  <= '0;
        end else if (train_start_i) begin
            open_q <= 1'b1;
            ptr_q  <= '0;
        end else if (store_o) begin
            if (ptr_q == LAST) begin
                open_q <= 1'b0;
                ptr_q  <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Read index: zero on readout entry, wrapping advance on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode_q <= 1'b0;
            rd_idx_q  <= '0;
        end else begin
            rd_mode_q <= readout_i;
            if (readout_i && !rd_mode_q)
                rd_idx_q <= '0;
            else if (readout_i && rd_strobe_i)
                rd_idx_q <= (rd_idx_q == LAST) ? '0 : rd_idx_q + 1'b1;
        end
    end

    assign rd_idx_o = rd_idx_q;

    AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (store_o && ptr_q == LAST) |=> !open_q); // R4
    AST_RD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_i && !rd_mode_q) |=> (rd_idx_q == '0)); // R7
    AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (readout_i && rd_mode_q && rd_strobe_i && rd_idx_q == LAST) |=> (rd_idx_q == '0)); // R7
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!readout_i) |=> $stable(rd_idx_q)); // R7
endmodule

// File: rtl/gsc_selector.sv
// Column and row token shift registers; a pixel is selected where a
// column token and a row token cross. Assumes steps are single-cycle.
module gsc_selector #(
    parameter int NUM_X = 3,
    parameter int NUM_Y = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xstep_i,
    input  logic                   xbit_i,
    input  logic                   ystep_i,
    input  logic                   ybit_i,
    output logic [NUM_X*NUM_Y-1:0] sel_o
);
    logic [NUM_X-1:0] x_q;
    logic [NUM_Y-1:0] y_q;

    // Column token shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       x_q <= '0;
        else if (xstep_i) x_q <= {x_q[NUM_X-2:0], xbit_i};
    end

    // Row token shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       y_q <= '0;
        else if (ystep_i) y_q <= {y_q[NUM_Y-2:0], ybit_i};
    end

    for (genvar iy = 0; iy < NUM_Y; iy++) begin : g_row
        for (genvar ix = 0; ix < NUM_X; ix++) begin : g_col
            assign sel_o[iy*NUM_X+ix] = x_q[ix] && y_q[iy];
        end
    end

    AST_X_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        xstep_i |=> (x_q[0] == $past(xbit_i))); // R9
    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xstep_i |=> $stable(x_q)); // R9
    AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ystep_i |=> $stable(y_q)); // R9
endmodule

// File: rtl/gsc_array_top.sv
// Hit counter array top: per-pixel sliced Gray counters, shared window
// and readout sequencer, token pixel selector and read data formatting.
// Assumes hit inputs are already synchronized to clk.
module gsc_array_top
    import gsc_pkg::*;
#(
    parameter int NUM_X      = 3,
    parameter int NUM_Y      = 3,
    parameter int NUM_SLICES = 16,
    localparam int NUM_PIX   = NUM_X * NUM_Y,
    localparam int IDX_W     = $clog2(NUM_SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PIX-1:0] hit_i,
    input  logic               train_start_i,
    input  logic               slice_end_i,
    input  logic               readout_i,
    input  logic               rd_strobe_i,
    input  logic               fmt_bin_i,
    input  logic               xstep_i,
    input  logic               xbit_i,
    input  logic               ystep_i,
    input  logic               ybit_i,
    output logic [NUM_PIX-1:0] pix_sel_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic [CNT_W-1:0]   data_o
);
    logic             count_en;
    logic             clear;
    logic             store;
    logic [IDX_W-1:0] store_idx;
    logic [IDX_W-1:0] rd_idx;
    count_t           rd_gray [NUM_PIX];
    count_t           picked;

    gsc_sequencer #(.NUM_SLICES(NUM_SLICES), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .train_start_i(train_start_i), .slice_end_i(slice_end_i),
        .readout_i(readout_i), .rd_strobe_i(rd_strobe_i),
        .count_en_o(count_en), .clear_o(clear), .store_o(store),
        .store_idx_o(store_idx), .rd_idx_o(rd_idx)
    );

    gsc_selector #(.NUM_X(NUM_X), .NUM_Y(NUM_Y)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .xstep_i(xstep_i), .xbit_i(xbit_i),
        .ystep_i(ystep_i), .ybit_i(ybit_i),
        .sel_o(pix_sel_o)
    );

    for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
        gsc_pixel #(.NUM_SLICES(NUM_SLICES), .IDX_W(IDX_W)) u_pix (
            .clk(clk), .rst_n(rst_n), .hit_i(hit_i[p]),
            .count_en_i(count_en), .clear_i(clear), .store_i(store),
            .store_idx_i(store_idx), .rd_idx_i(rd_idx),
            .rd_gray_o(rd_gray[p])
        );
    end

    // Merge the selected pixels' slice values and apply the output format.
    always_comb begin
        picked = '0;
        for (int p = 0; p < NUM_PIX; p++) begin
            if (pix_sel_o[p]) picked = picked | rd_gray[p];
        end
        if (!readout_i)     data_o = '0;
        else if (fmt_bin_i) data_o = gray2bin(picked);
        else                data_o = picked;
    end

    assign rd_idx_o = rd_idx;

    AST_NO_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel_o == '0) |-> (data_o == '0)); // R10
endmodule

// File: tb/gsc_array_top_tb.sv
module gsc_array_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 9;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hit_i = '0;
    logic          train_start_i = 1'b0, slice_end_i = 1'b0, readout_i = 1'b0;
    logic          rd_strobe_i = 1'b0, fmt_bin_i = 1'b0;
    logic          xstep_i = 1'b0, xbit_i = 1'b0, ystep_i = 1'b0, ybit_i = 1'b0;
    logic [NP-1:0] pix_sel_o;
    logic [3:0]    rd_idx_o;
    logic [7:0]    data_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model of the requirements.
    int  m_slot [NP][NS];
    int  m_cnt  [NP];
    bit  m_open = 0;
    int  m_ptr  = 0;

    gsc_array_top u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i),
        .train_start_i(train_start_i), .slice_end_i(slice_end_i),
        .readout_i(readout_i), .rd_strobe_i(rd_strobe_i), .fmt_bin_i(fmt_bin_i),
        .xstep_i(xstep_i), .xbit_i(xbit_i), .ystep_i(ystep_i), .ybit_i(ybit_i),
        .pix_sel_o(pix_sel_o), .rd_idx_o(rd_idx_o), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int to_gray(input int b);
        return (b ^ (b >> 1)) & 8'hFF;
    endfunction

    // One counting cycle, driven at a falling edge, with the model update.
    task automatic step(input logic [NP-1:0] h, input logic ts, input logic se);
        bit cen;
        hit_i = h; train_start_i = ts; slice_end_i = se;
        @(posedge clk);
        cen = (m_open || ts) && !readout_i;
        if (ts) begin
            for (int p = 0; p < NP; p++) begin
                for (int s = 0; s < NS; s++) m_slot[p][s] = 0;
                m_cnt[p] = (h[p] && cen) ? 1 : 0;
            end
            m_open = 1; m_ptr = 0;
        end else if (se && m_open && !readout_i) begin
            for (int p = 0; p < NP; p++) begin
                m_slot[p][m_ptr] = m_cnt[p];
                m_cnt[p] = (h[p] && cen) ? 1 : 0;
            end
            if (m_ptr == NS-1) begin m_open = 0; m_ptr = 0; end
            else m_ptr++;
        end else if (cen) begin
            for (int p = 0; p < NP; p++)
                if (h[p] && m_cnt[p] < 255) m_cnt[p]++;
        end
        @(negedge clk);
        hit_i = '0; train_start_i = 1'b0; slice_end_i = 1'b0;
    endtask

    task automatic sel_step(input logic xs, input logic xb, input logic ys, input logic yb);
        xstep_i = xs; xbit_i = xb; ystep_i = ys; ybit_i = yb;
        @(negedge clk);
        xstep_i = 1'b0; xbit_i = 1'b0; ystep_i = 1'b0; ybit_i = 1'b0;
    endtask

    task automatic select_pixel(input int ix, input int iy);
        for (int i = 0; i < 3; i++) sel_step(1, 0, 1, 0);
        sel_step(1, 1, 1, 1);
        for (int i = 0; i < ix; i++) sel_step(1, 0, 0, 0);
        for (int i = 0; i < iy; i++) sel_step(0, 0, 1, 0);
        check("R9 select one-hot", int'(pix_sel_o), 1 << (iy*3+ix));
    endtask

    // Enter readout, read all slices of one pixel in both formats, leave.
    task automatic read_pixel(input int p);
        select_pixel(p % 3, p / 3);
        readout_i = 1'b1;
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            check("R7 read index", int'(rd_idx_o), s);
            fmt_bin_i = 1'b0; #1;
            check("R8 gray read", int'(data_o), to_gray(m_slot[p][s]));
            fmt_bin_i = 1'b1; #1;
            check("R8 binary read", int'(data_o), m_slot[p][s]);
            rd_strobe_i = 1'b1;
            @(negedge clk);
            rd_strobe_i = 1'b0;
        end
        check("R7 index wraps to 0", int'(rd_idx_o), 0);
        readout_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 no selection", int'(pix_sel_o), 0);
        check("R11 read index", int'(rd_idx_o), 0);
        check("R10 idle data", int'(data_o), 0);
        step(9'h1FF, 0, 0);
        step(0, 0, 1);
        read_pixel(4);   // window closed after reset: slices all zero (R11)
    endtask

    task automatic t_selector;
        for (int i = 0; i < 3; i++) sel_step(1, 0, 1, 0);
        readout_i = 1'b1; #1;
        check("R10 no pixel selected", int'(data_o), 0);
        readout_i = 1'b0;
        sel_step(0, 0, 1, 1);
        sel_step(1, 1, 0, 0);
        check("R9 first step col0", int'(pix_sel_o), 1);
        sel_step(1, 0, 0, 0);
        check("R9 second step col1", int'(pix_sel_o), 2);
        sel_step(1, 0, 0, 0);
        check("R9 third step col2", int'(pix_sel_o), 4);
        sel_step(0, 0, 0, 0);
        check("R9 hold without step", int'(pix_sel_o), 4);
    endtask

    task automatic t_fill;
        step(0, 1, 0);
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < 20; c++) begin
                logic [NP-1:0] h = '0;
                for (int p = 0; p < NP; p++) h[p] = (c < ((p*5 + s*3) % 17));
                step(h, 0, 0);
            end
            if (s == 5) for (int c = 0; c < 300; c++) step(9'h001, 0, 0); // R2
            step(9'h010, 0, 1); // R3 boundary hit on pixel 4
        end
        for (int c = 0; c < 10; c++) step(9'h1FF, 0, 0);   // R4 closed window
        step(9'h1FF, 0, 1);
        check("R2 saturated model", m_slot[0][5], 255);
        for (int p = 0; p < NP; p++) read_pixel(p);         // R1 R3 R4 R8
    endtask

    task automatic t_inhibit;
        step(0, 1, 0);
        for (int c = 0; c < 3; c++) step(9'h002, 0, 0);
        readout_i = 1'b1;
        for (int c = 0; c < 5; c++) step(9'h002, 0, 0);     // R6
        step(9'h002, 0, 1);
        readout_i = 1'b0;
        step(0, 0, 1);
        check("R6 model slot0", m_slot[1][0], 3);
        read_pixel(1);
    endtask

    task automatic t_clear;
        step(9'h005, 1, 0);   // R5 hit with train start
        step(0, 0, 1);
        check("R5 model slot0", m_slot[0][0], 1);
        read_pixel(0);
        read_pixel(2);
        readout_i = 1'b0; fmt_bin_i = 1'b0; #1;
        check("R10 data idle out of readout", int'(data_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_cnt[p] = 0;
            for (int s = 0; s < NS; s++) m_slot[p][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_selector;
        t_fill;
        t_inhibit;
        t_clear;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule